// File: doc/BRIEF.md
# Quadrature Carrier NCO with Phase Offset

This block generates the cosine and sine samples that a mixer stage uses to bring a digitized IF stream down to baseband. A 32-bit phase accumulator advances by a frequency word on every input-clock cycle in which the clock enable is high. A 10-bit phase offset is added, modulo one turn, to the top of the accumulator. The 12 most significant bits of that sum address a quarter-wave sine table that is computed at elaboration. Two's-complement 18-bit cosine and sine results come out two cycles after the enabled cycle.

The frequency word has two sources. A register-style port writes all 32 bits at once. A serial input takes a word MSB first, with a sync strobe marking its first bit. Serial words may be 1 to 32 bits long, and words as short as 8 bits arrive back to back with no idle cycle. The completed word is transferred in a single cycle, so the accumulator never adds a partly shifted value.

The output is a stream with a valid flag and no ready input. The mixer takes one sample for every enabled input cycle and cannot stall the oscillator, so back-pressure is not supported: a consumer must accept every cycle in which `out_valid` is high.

Top module: `carrier_nco`

## Requirements
- R1: A synchronous reset clears the accumulator, the frequency word, any serial word in progress and `out_valid`. With a zero frequency word and zero offset, the first sample after reset is cosine 131071, sine 0.
- R2: On each clock edge with `en` high, the accumulator adds the current frequency word modulo 2^32. With `en` low the accumulator holds, and no sample is produced for that cycle.
- R3: The table index is bits 31:20 of the accumulator plus `phase_ofs` shifted left by 2, taken modulo 4096. One offset LSB is 360/1024 degrees, so an offset of 256 alone gives a quarter turn (sine 131071, cosine 0).
- R4: For a table index p, sine = round(131071·sin(2πp/4096)) and cosine = round(131071·cos(2πp/4096)), with halves rounded away from zero. Both are 18-bit two's complement.
- R5: `out_valid` is high exactly two cycles after a cycle with `en` high. The sample it carries is taken from the accumulator value that was present before that enabled step, combined with the `phase_ofs` of that cycle.
- R6: A cycle with `freq_wr` high loads `freq_wdata` as the frequency word. The accumulation step at the same edge still uses the previous word.
- R7: A serial word starts in the cycle where `ser_sync` is high; that cycle's `ser_data` is the MSB. The length is `ser_bits`+1, sampled with the sync. The word is placed in the upper bits of the frequency word, and the lower bits are zero.
- R8: The serial word replaces the frequency word at the edge that shifts in its last bit. An accumulation step at that same edge uses the old word, and no partly shifted value is ever used.
- R9: A new `ser_sync` may come in the cycle right after the last bit of a word. A `ser_sync` in the middle of a word drops that word and starts a new one.
- R10: If a register write and a serial completion fall on the same edge, the register write wins and the serial word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for one accumulation step |
| freq_wr | input | 1 | Register write strobe for the frequency word |
| freq_wdata | input | 32 | Frequency word written in parallel |
| ser_data | input | 1 | Serial frequency bit, MSB first |
| ser_sync | input | 1 | Marks the first bit of a serial word |
| ser_bits | input | 5 | Serial word length minus one, sampled with the sync |
| phase_ofs | input | 10 | Phase offset, 1/1024 turn per LSB |
| out_valid | output | 1 | A cosine/sine pair is present |
| out_cos | output | 18 | Cosine sample, two's complement |
| out_sin | output | 18 | Sine sample, two's complement |

## Verification
A serial word can complete at the same edge as an enabled accumulation step, and also at the same edge as a register write. The bench drives serial words with `en` held high through the last bit. It also raises `freq_wr` in exactly the cycle that carries a word's last bit. A reference model steps the accumulator with the old word and applies the register write in preference to the serial word. Any premature or wrong frequency then shows up as a mismatch in later cosine/sine samples.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int NCO_ACC_W = 32;
  localparam int NCO_OFS_W = 10;
  localparam int NCO_PH_W  = 12;
  localparam int NCO_OUT_W = 18;
  localparam real NCO_TWO_PI = 6.283185307179586;

  // Quarter-wave entry i of a table with 2**qb steps per quadrant, rounded.
  function automatic int nco_quarter_val(input int i, input int qb, input int amp);
    real x;
    x = real'(amp) * $sin(NCO_TWO_PI * real'(i) / real'(4 * (2 ** qb)));
    return $rtoi(x + 0.5);
  endfunction
endpackage

// File: rtl/nco_freq_loader.sv
module nco_freq_loader #(
  parameter int ACC_W = nco_pkg::NCO_ACC_W,
  parameter int LEN_W = $clog2(ACC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ACC_W-1:0] wdata,
  input  logic             ser_data,
  input  logic             ser_sync,
  input  logic [LEN_W-1:0] ser_bits,
  output logic [ACC_W-1:0] freq
);
  localparam int CW = LEN_W + 1;

  logic [ACC_W-1:0] sh_q, sh_n, word;
  logic [CW-1:0]    cnt_q, cnt_n, len_q, len_eff, shamt;
  logic             busy_q, done, active;

  always_comb begin
    active  = ser_sync || busy_q;
    sh_n    = ser_sync ? {{(ACC_W-1){1'b0}}, ser_data} : {sh_q[ACC_W-2:0], ser_data};
    cnt_n   = ser_sync ? CW'(1) : cnt_q + CW'(1);
    len_eff = ser_sync ? ({1'b0, ser_bits} + CW'(1)) : len_q;
    done    = active && (cnt_n == len_eff);
    shamt   = CW'(ACC_W) - len_eff;
    word    = sh_n << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      freq   <= '0;
    end else begin
      if (active) begin
        sh_q  <= sh_n;
        cnt_q <= cnt_n;
        len_q <= len_eff;
      end
      busy_q <= active && !done;
      if (wr)        freq <= wdata;   // R10: register write has priority
      else if (done) freq <= word;    // R8: whole word in one transfer
    end
  end

  // R8: the word changes only through a write or a completed serial word
  a_r8_freq_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr && !done) |=> $stable(freq));
  // R7: bits below a short serial word arrive as zero
  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (done && !wr && len_eff < CW'(ACC_W)) |=> ((freq << $past(len_eff)) == '0));
  // R10: a write lands even when a serial word completes with it
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr |=> (freq == $past(wdata)));
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
  parameter int ACC_W = nco_pkg::NCO_ACC_W,
  parameter int OFS_W = nco_pkg::NCO_OFS_W,
  parameter int PH_W  = nco_pkg::NCO_PH_W,
  localparam int QB   = PH_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] freq,
  input  logic [OFS_W-1:0] ofs,
  output logic             v1,
  output logic [QB:0]      addr_s,
  output logic [QB:0]      addr_c,
  output logic             neg_s,
  output logic             neg_c
);
  localparam int GAP = PH_W - OFS_W;

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  ph_s, ph_c;
  logic [QB+1:0]    f_s, f_c;

  // Fold a full-turn index onto the quarter table: {negate, address}
  function automatic logic [QB+1:0] fold(input logic [PH_W-1:0] p);
    logic [QB:0] r;
    r = {1'b0, p[QB-1:0]};
    if (p[QB]) r = (QB+1)'(2 ** QB) - r;
    return {p[PH_W-1], r};
  endfunction

  always_comb begin
    ph_s = acc_q[ACC_W-1 -: PH_W] + (PH_W'(ofs) << GAP);  // R3: modulo one turn
    ph_c = ph_s + PH_W'(2 ** QB);
    f_s  = fold(ph_s);
    f_c  = fold(ph_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      v1     <= 1'b0;
      addr_s <= '0;
      addr_c <= '0;
      neg_s  <= 1'b0;
      neg_c  <= 1'b0;
    end else begin
      v1 <= en;
      if (en) begin
        acc_q  <= acc_q + freq;
        addr_s <= f_s[QB:0];
        addr_c <= f_c[QB:0];
        neg_s  <= f_s[QB+1];
        neg_c  <= f_c[QB+1];
      end
    end
  end

  // R2: a disabled cycle leaves the accumulator alone
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
  // R3: quarter-table address never leaves the table
  a_r3_addr_range: assert property (@(posedge clk) disable iff (rst)
    v1 |-> (addr_s <= (QB+1)'(2 ** QB) && addr_c <= (QB+1)'(2 ** QB)));
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int PH_W  = nco_pkg::NCO_PH_W,
  parameter int OUT_W = nco_pkg::NCO_OUT_W,
  localparam int QB   = PH_W - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v1,
  input  logic [QB:0]             addr_s,
  input  logic [QB:0]             addr_c,
  input  logic                    neg_s,
  input  logic                    neg_c,
  output logic                    valid,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam int AMP   = 2 ** (OUT_W - 1) - 1;
  localparam int DEPTH = 2 ** QB + 1;

  logic signed [OUT_W-1:0] tbl [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      tbl[i] = OUT_W'(nco_pkg::nco_quarter_val(i, QB, AMP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      valid <= v1;
      sin_o <= neg_s ? -tbl[addr_s] : tbl[addr_s];
      cos_o <= neg_c ? -tbl[addr_c] : tbl[addr_c];
    end
  end

  // R4: samples stay inside the symmetric amplitude
  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    valid |-> (sin_o >= -OUT_W'(AMP) && sin_o <= OUT_W'(AMP) &&
               cos_o >= -OUT_W'(AMP) && cos_o <= OUT_W'(AMP)));
  // R4: a quadrature pair is never both zero
  a_r4_not_null: assert property (@(posedge clk) disable iff (rst)
    valid |-> !(sin_o == '0 && cos_o == '0));
endmodule

// File: rtl/carrier_nco.sv
module carrier_nco #(
  parameter int ACC_W = nco_pkg::NCO_ACC_W,
  parameter int OFS_W = nco_pkg::NCO_OFS_W,
  parameter int PH_W  = nco_pkg::NCO_PH_W,
  parameter int OUT_W = nco_pkg::NCO_OUT_W,
  parameter int LEN_W = $clog2(ACC_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    freq_wr,
  input  logic [ACC_W-1:0]        freq_wdata,
  input  logic                    ser_data,
  input  logic                    ser_sync,
  input  logic [LEN_W-1:0]        ser_bits,
  input  logic [OFS_W-1:0]        phase_ofs,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_cos,
  output logic signed [OUT_W-1:0] out_sin
);
  localparam int QB = PH_W - 2;

  logic [ACC_W-1:0] freq;
  logic             v1, neg_s, neg_c;
  logic [QB:0]      addr_s, addr_c;

  nco_freq_loader #(.ACC_W(ACC_W), .LEN_W(LEN_W)) u_load (
    .clk, .rst, .wr(freq_wr), .wdata(freq_wdata), .ser_data, .ser_sync,
    .ser_bits, .freq
  );

  nco_phase_gen #(.ACC_W(ACC_W), .OFS_W(OFS_W), .PH_W(PH_W)) u_phase (
    .clk, .rst, .en, .freq, .ofs(phase_ofs), .v1, .addr_s, .addr_c,
    .neg_s, .neg_c
  );

  nco_sincos_rom #(.PH_W(PH_W), .OUT_W(OUT_W)) u_rom (
    .clk, .rst, .v1, .addr_s, .addr_c, .neg_s, .neg_c,
    .valid(out_valid), .cos_o(out_cos), .sin_o(out_sin)
  );

  // R5: fixed two-cycle latency from an enabled cycle to a valid sample
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    en |=> ##1 out_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !en |=> ##1 !out_valid);
  // R1: reset clears the sample stream
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/carrier_nco_test.sv
module carrier_nco_test;
  localparam int AMP = 131071;

  logic        clk = 1'b0;
  logic        rst = 1'b1, en = 1'b0, freq_wr = 1'b0, ser_data = 1'b0, ser_sync = 1'b0;
  logic [31:0] freq_wdata = '0;
  logic [4:0]  ser_bits = '0;
  logic [9:0]  phase_ofs = '0;
  logic        out_valid;
  logic signed [17:0] out_cos, out_sin;

  carrier_nco uut (
    .clk, .rst, .en, .freq_wr, .freq_wdata, .ser_data, .ser_sync, .ser_bits,
    .phase_ofs, .out_valid, .out_cos, .out_sin
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  // reference model state
  logic [31:0] m_acc, m_freq;
  int          m_ph, m_cos, m_sin;
  bit          m_v1, m_v2;
  longint      s_word;
  int          s_cnt, s_len;
  bit          s_busy;

  function automatic int sinval(input int p);
    real x;
    x = real'(AMP) * $sin(6.283185307179586 * real'(p) / 4096.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit done;
    if (rst) begin
      m_acc = '0; m_freq = '0; m_v1 = 0; m_v2 = 0; m_ph = 0;
      s_busy = 0; s_cnt = 0; s_len = 0; s_word = 0;
      return;
    end
    m_v2 = m_v1;
    if (m_v1) begin
      m_sin = sinval(m_ph);
      m_cos = sinval((m_ph + 1024) % 4096);
    end
    m_v1 = en;
    if (en) begin
      m_ph  = (int'(m_acc >> 20) + int'(phase_ofs) * 4) % 4096;
      m_acc = m_acc + m_freq;
    end
    if (ser_sync) begin
      s_cnt = 1; s_len = int'(ser_bits) + 1; s_word = longint'(ser_data); s_busy = 1;
    end else if (s_busy) begin
      s_cnt++; s_word = (s_word << 1) | longint'(ser_data);
    end
    done = s_busy && (s_cnt == s_len);
    if (done) s_busy = 0;
    if (freq_wr) m_freq = freq_wdata;
    else if (done) m_freq = 32'(s_word << (32 - s_len));
  endtask

  task automatic compare();
    check(out_valid == m_v2, "R5 valid", int'(out_valid), int'(m_v2));
    if (m_v2 && out_valid) begin
      check(int'(out_sin) == m_sin, {tag, " sine"}, int'(out_sin), m_sin);
      check(int'(out_cos) == m_cos, {tag, " cosine"}, int'(out_cos), m_cos);
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    freq_wr = 1'b0;
    ser_sync = 1'b0;
  endtask

  task automatic send_serial(input logic [31:0] w, input int nbits, input int stop_at,
                             input bit en_hi, input bit wr_last);
    for (int i = 0; i < nbits && i < stop_at; i++) begin
      ser_sync = (i == 0);
      ser_data = w[nbits-1-i];
      ser_bits = 5'(nbits - 1);
      en = en_hi ? 1'b1 : 1'($urandom_range(0, 1));
      if (wr_last && i == nbits - 1) begin
        freq_wr = 1'b1;
        freq_wdata = $urandom;
      end
      cycle();
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    // R1: reset state
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cycle();
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    rst = 1'b0; en = 1'b1;
    cycle(); cycle();
    check(out_valid && out_cos == 18'sd131071 && out_sin == 0, "R1 first sample",
          int'(out_cos), AMP);

    // R3: quarter-turn offset, then wrap of offset plus accumulator
    tag = "R3";
    phase_ofs = 10'd256;
    cycle(); cycle(); cycle();
    check(out_sin == 18'sd131071, "R3 quarter offset sine", int'(out_sin), AMP);
    check(out_cos == 0, "R3 quarter offset cosine", int'(out_cos), 0);
    phase_ofs = 10'd1023;
    freq_wr = 1'b1; freq_wdata = 32'h0010_0000;
    for (int i = 0; i < 12; i++) cycle();

    // R4: random words and offsets, always enabled
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 0) begin freq_wr = 1'b1; freq_wdata = $urandom; end
      phase_ofs = 10'($urandom);
      cycle();
    end

    // R2: enable toggling
    tag = "R2";
    for (int i = 0; i < 300; i++) begin
      en = 1'($urandom_range(0, 1));
      if (i % 25 == 0) begin freq_wr = 1'b1; freq_wdata = $urandom; end
      cycle();
    end

    // R6: frequent register writes
    tag = "R6";
    en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      freq_wr = 1'($urandom_range(0, 1));
      freq_wdata = $urandom;
      cycle();
    end

    // R7: serial words of random length with idle gaps
    tag = "R7";
    for (int k = 0; k < 40; k++) begin
      send_serial($urandom, $urandom_range(8, 32), 99, 1'b0, 1'b0);
      for (int g = 0; g < int'($urandom_range(0, 3)); g++) cycle();
    end

    // R8: completion lands on an enabled step
    tag = "R8";
    for (int k = 0; k < 30; k++) send_serial($urandom, $urandom_range(8, 32), 99, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cycle();

    // R9: zero-gap 8-bit words and restart mid-word
    tag = "R9";
    for (int k = 0; k < 30; k++) send_serial($urandom, 8, 99, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) begin
      send_serial($urandom, 24, $urandom_range(1, 20), 1'b1, 1'b0);
      send_serial($urandom, $urandom_range(8, 32), 99, 1'b1, 1'b0);
    end
    for (int i = 0; i < 5; i++) cycle();

    // R10: register write in the cycle of the last serial bit
    tag = "R10";
    for (int k = 0; k < 30; k++) begin
      send_serial($urandom, $urandom_range(8, 32), 99, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) cycle();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule